// File: doc/BRIEF.md
# Skip-Generating Accumulator ALU

This block is the 8-bit arithmetic stage of a small sequencer in which arithmetic results steer control flow through a skip request, not a branch flag. One operand is always the accumulator pair. The other is any second register pair. On each accepted operation the block returns a result, a write enable for that result, a new carry value with its own update enable, and a skip request. The sequencer uses the skip request to discard the next instruction.

Each opcode has its own skip rule. The skip can come from the incremented value reaching zero, from a carry out of the top bit, from a borrow, or from equality of the two operands. Only the carry-chained add and subtract touch the carry flag. Program-counter handling and register storage sit outside the block.

Operations are presented with a valid strobe. All outputs are registered and appear on the clock edge after the strobe, qualified by an output valid.

Top module: `acc_skip_alu`

## Requirements
- R1: After synchronous reset the outputs `out_vld`, `res_we`, `cy_we`, `skip` and `res` are all zero.
- R2: Every output that `in_vld` accepts appears exactly one clock later with `out_vld` high. A cycle without `in_vld` produces `out_vld`, `res_we`, `cy_we` and `skip` all low on the next clock.
- R3: Opcode 0 (move) gives `res` = `opb` with `res_we` high and `skip` low.
- R4: Opcode 1 (increment-and-skip) gives `res` = (`opb` + 1) mod 256 with `res_we` high. `skip` is high exactly when that result is 00h.
- R5: Opcode 2 (add-and-skip) gives `res` = (`opa` + `opb`) mod 256 with `res_we` high. `skip` is high exactly when the true sum exceeds 255.
- R6: Opcode 3 (add with carry) gives `res` = (`opa` + `opb` + `cy_in`) mod 256, with `cy_we` high and `cy_out` high exactly when the true sum exceeds 255. `skip` is low.
- R7: Opcode 4 (subtract with carry) treats `opb` as the destination. It gives `res` = (`opb` − `opa` − `cy_in`) mod 256 with `res_we` high and `cy_we` high. `cy_out` is 1 exactly when `opb` < `opa` + `cy_in`. `skip` is low.
- R8: Opcode 5 (subtract-and-skip) gives `res` = (`opa` − `opb`) mod 256 with `res_we` high. `skip` is high exactly when `opa` < `opb`.
- R9: Opcode 6 (compare-and-skip) keeps `res_we` low. `skip` is high exactly when `opa` equals `opb`.
- R10: Opcode 7 is a no-operation. `res_we`, `cy_we` and `skip` stay low.
- R11: Every opcode other than 3 and 4 keeps `cy_we` low, and `cy_out` then equals the `cy_in` of that same operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| op | input | 3 | Opcode (encoding per R3 to R10) |
| opa | input | 8 | Accumulator pair value |
| opb | input | 8 | Second register pair value (destination for opcode 4) |
| cy_in | input | 1 | Current carry flag |
| out_vld | output | 1 | Registered result valid |
| res | output | 8 | Result value |
| res_we | output | 1 | Result write enable |
| cy_out | output | 1 | New carry value |
| cy_we | output | 1 | Carry update enable |
| skip | output | 1 | Skip-next-instruction request |

## Verification
A result write and a skip request can occur in the same cycle. This happens when an increment wraps to zero, when an add-and-skip carries, and when a subtract-and-skip borrows. A carry update and a result write can also coincide, in both carry-chained operations. The sweep covers every accumulator value against a set of second operands clustered at 00h, 7Fh/80h and FEh/FFh, and it includes the case where the second operand equals the accumulator, under both carry inputs, so that every one of these overlaps occurs. Each result is compared in full against arithmetic model values: result, both enables, carry and skip are judged together in the cycle after the strobe.

// File: rtl/askp_pkg.sv
package askp_pkg;

  typedef enum logic [2:0] {
    OP_MOV  = 3'd0,
    OP_INCS = 3'd1,
    OP_ADDS = 3'd2,
    OP_ADDC = 3'd3,
    OP_SUBC = 3'd4,
    OP_SUBS = 3'd5,
    OP_SKE  = 3'd6,
    OP_NOP  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2
  } cin_e;

  typedef enum logic [1:0] {
    SK_NONE  = 2'd0,
    SK_CARRY = 2'd1,
    SK_ZERO  = 2'd2,
    SK_EQ    = 2'd3
  } skip_e;

  typedef enum logic [1:0] {
    RT_PAIR = 2'd0,
    RT_SWAP = 2'd1,
    RT_INC  = 2'd2
  } route_e;

  typedef struct packed {
    route_e route;
    logic   sub;
    cin_e   cin;
    logic   pass;
    logic   wr;
    logic   cyw;
    skip_e  skp;
  } ctl_t;

endpackage

// File: rtl/askp_ctrl.sv
module askp_ctrl
  import askp_pkg::*;
(
  input  logic [2:0] op_i,
  output ctl_t       ctl_o
);

  always_comb begin
    ctl_o = '{route: RT_PAIR, sub: 1'b0, cin: CIN_ZERO, pass: 1'b0,
              wr: 1'b0, cyw: 1'b0, skp: SK_NONE};
    case (op_e'(op_i))
      OP_MOV: begin
        ctl_o.pass = 1'b1;
        ctl_o.wr   = 1'b1;
      end
      OP_INCS: begin
        ctl_o.route = RT_INC;
        ctl_o.cin   = CIN_ONE;
        ctl_o.wr    = 1'b1;
        ctl_o.skp   = SK_ZERO;
      end
      OP_ADDS: begin
        ctl_o.wr  = 1'b1;
        ctl_o.skp = SK_CARRY;
      end
      OP_ADDC: begin
        ctl_o.cin = CIN_FLAG;
        ctl_o.wr  = 1'b1;
        ctl_o.cyw = 1'b1;
      end
      OP_SUBC: begin
        ctl_o.route = RT_SWAP;
        ctl_o.sub   = 1'b1;
        ctl_o.cin   = CIN_FLAG;
        ctl_o.wr    = 1'b1;
        ctl_o.cyw   = 1'b1;
      end
      OP_SUBS: begin
        ctl_o.sub = 1'b1;
        ctl_o.wr  = 1'b1;
        ctl_o.skp = SK_CARRY;
      end
      OP_SKE: begin
        ctl_o.skp = SK_EQ;
      end
      default: begin
        ctl_o.pass = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/askp_addsub.sv
// Shared adder: add gives carry-out, subtract gives borrow-out on flag_o.
// Subtract is formed as a + ~b + (1 - cin).
module askp_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         flag_o
);

  logic [W-1:0] b_x;
  logic         c_x;
  logic [W:0]   total;

  always_comb begin
    b_x    = sub_i ? ~b_i : b_i;
    c_x    = sub_i ? ~cin_i : cin_i;
    total  = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, c_x};
    sum_o  = total[W-1:0];
    flag_o = sub_i ? ~total[W] : total[W];
  end

endmodule

// File: rtl/askp_skipsel.sv
module askp_skipsel
  import askp_pkg::*;
#(
  parameter int W = 8
) (
  input  skip_e        sel_i,
  input  logic         flag_i,
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         skip_o
);

  always_comb begin
    case (sel_i)
      SK_CARRY: skip_o = flag_i;
      SK_ZERO:  skip_o = (sum_i == '0);
      SK_EQ:    skip_o = (a_i == b_i);
      default:  skip_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_skip_alu.sv
module acc_skip_alu
  import askp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [2:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cy_in,
  output logic         out_vld,
  output logic [W-1:0] res,
  output logic         res_we,
  output logic         cy_out,
  output logic         cy_we,
  output logic         skip
);

  ctl_t         ctl;
  logic [W-1:0] add_a;
  logic [W-1:0] add_b;
  logic         add_c;
  logic [W-1:0] sum;
  logic         flag;
  logic         skip_n;
  logic [W-1:0] res_n;

  askp_ctrl u_ctrl (
    .op_i  (op),
    .ctl_o (ctl)
  );

  always_comb begin
    case (ctl.route)
      RT_SWAP: begin add_a = opb; add_b = opa; end
      RT_INC:  begin add_a = opb; add_b = '0;  end
      default: begin add_a = opa; add_b = opb; end
    endcase
    case (ctl.cin)
      CIN_ONE:  add_c = 1'b1;
      CIN_FLAG: add_c = cy_in;
      default:  add_c = 1'b0;
    endcase
  end

  askp_addsub #(.W(W)) u_addsub (
    .a_i    (add_a),
    .b_i    (add_b),
    .cin_i  (add_c),
    .sub_i  (ctl.sub),
    .sum_o  (sum),
    .flag_o (flag)
  );

  askp_skipsel #(.W(W)) u_skipsel (
    .sel_i  (ctl.skp),
    .flag_i (flag),
    .sum_i  (sum),
    .a_i    (opa),
    .b_i    (opb),
    .skip_o (skip_n)
  );

  assign res_n = ctl.pass ? opb : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      res     <= '0;
      res_we  <= 1'b0;
      cy_out  <= 1'b0;
      cy_we   <= 1'b0;
      skip    <= 1'b0;
    end else begin
      out_vld <= in_vld;
      res_we  <= in_vld & ctl.wr;
      cy_we   <= in_vld & ctl.cyw;
      skip    <= in_vld & skip_n;
      cy_out  <= (in_vld && ctl.cyw) ? flag : cy_in;
      if (in_vld) res <= res_n;
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> (!out_vld && !res_we && !cy_we && !skip));

  a_r2_one_cycle: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  a_r3_move_pass: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == 3'(OP_MOV)) |=> (res == $past(opb) && res_we && !skip));

  a_r9_compare_no_write: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == 3'(OP_SKE)) |=> (!res_we && skip == ($past(opa) == $past(opb))));

  a_r10_nop_silent: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op == 3'(OP_NOP)) |=> (!res_we && !cy_we && !skip));

  a_r11_carry_hold: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op != 3'(OP_ADDC) && op != 3'(OP_SUBC)) |=> (!cy_we && cy_out == $past(cy_in)));

  a_r6_carry_update: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (op == 3'(OP_ADDC) || op == 3'(OP_SUBC))) |=> (cy_we && res_we && !skip));

endmodule

// File: tb/acc_skip_alu_tb_top.sv
module acc_skip_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] opa = 8'd0;
  logic [7:0] opb = 8'd0;
  logic       cy_in = 1'b0;
  logic       out_vld;
  logic [7:0] res;
  logic       res_we;
  logic       cy_out;
  logic       cy_we;
  logic       skip;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  acc_skip_alu #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op(op), .opa(opa), .opb(opb),
    .cy_in(cy_in), .out_vld(out_vld), .res(res), .res_we(res_we),
    .cy_out(cy_out), .cy_we(cy_we), .skip(skip)
  );

  function automatic string tag_of(int o);
    case (o)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R8";
      6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic run_one(int o, int a, int b, int c);
    int  t, e_res, e_cyo;
    bit  e_we, e_cyw, e_sk;
    bit  ok;
    e_res = 0; e_we = 0; e_cyw = 0; e_sk = 0; e_cyo = c;
    case (o)
      0: begin e_res = b; e_we = 1; end
      1: begin t = b + 1; e_res = t % 256; e_we = 1; e_sk = (e_res == 0); end
      2: begin t = a + b; e_res = t % 256; e_we = 1; e_sk = (t > 255); end
      3: begin t = a + b + c; e_res = t % 256; e_we = 1; e_cyw = 1; e_cyo = (t > 255); end
      4: begin t = b - a - c + 512; e_res = t % 256; e_we = 1; e_cyw = 1; e_cyo = (b < a + c); end
      5: begin t = a - b + 256; e_res = t % 256; e_we = 1; e_sk = (a < b); end
      6: begin e_sk = (a == b); end
      default: ;
    endcase
    @(negedge clk);
    in_vld = 1'b1; op = 3'(o); opa = 8'(a); opb = 8'(b); cy_in = 1'(c);
    @(negedge clk);
    ok = out_vld && (res_we == e_we) && (cy_we == e_cyw) && (skip == e_sk)
         && (cy_out == 1'(e_cyo)) && (!e_we || res == 8'(e_res));
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s (R2/R11) op=%0d a=%0h b=%0h cy=%0d: got vld=%0b res=%0h we=%0b cyo=%0b cyw=%0b sk=%0b exp res=%0h we=%0b cyo=%0b cyw=%0b sk=%0b",
               tag_of(o), o, a, b, c, out_vld, res, res_we, cy_out, cy_we, skip,
               e_res, e_we, e_cyo, e_cyw, e_sk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    int blist[12] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h7E,
                      8'h7F, 8'h80, 8'h81, 8'hA5, 8'hFE, 8'hFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (out_vld || res_we || cy_we || skip || res != 8'h00) begin
      n_bad++;
      $display("FAIL R1: got vld=%0b we=%0b cyw=%0b sk=%0b res=%0h expected all zero",
               out_vld, res_we, cy_we, skip, res);
    end

    for (int o = 0; o < 8; o++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 256; a++) begin
          for (int k = 0; k < 12; k++) run_one(o, a, blist[k], c);
          run_one(o, a, a, c);
        end

    // R2: idle cycle with skip-provoking operands stays quiet
    @(negedge clk);
    in_vld = 1'b0; op = 3'd2; opa = 8'hFF; opb = 8'h01; cy_in = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (out_vld || res_we || cy_we || skip) begin
      n_bad++;
      $display("FAIL R2: idle got vld=%0b we=%0b cyw=%0b sk=%0b expected 0 0 0 0",
               out_vld, res_we, cy_we, skip);
    end
    finish_run();
  end

endmodule